// File: doc/BRIEF.md
# HCI Command Framer and Event Deframer

This block turns a command descriptor (a 16-bit command opcode and an 8-bit parameter count) plus a stream of parameter bytes into the serialized byte sequence of a vendor-specific host-controller command. The sequence feeds an SPI transaction controller as the payload of a write transaction. The first byte the framer presents is the first byte of the command, so the controller places it right after its own write opcode with nothing in between. The byte output uses a valid/ready handshake, and the parameter input uses another.

The frame is laid out as follows. A fixed packet-type byte comes first. The opcode follows, low byte first. Then comes the one-byte parameter count, and then the parameters exactly as supplied. Multi-byte parameters are already little-endian in the stream, and the framer keeps their order. If the parameter stream ends early or late against the declared count, the framer aborts the packet and pulses an error.

A separate deframer watches event bytes coming back from the controller. It marks the first and last byte of each event and tells header bytes from parameter bytes. Each event is a type byte, an event code, a length byte and then that many parameter bytes.

Top module: `hci_pkt_framer`

## Requirements
- R1: After a descriptor is accepted, the first byte presented on outData is 0x01.
- R2: The second and third bytes presented are the opcode's bits 7:0 and bits 15:8, in that order.
- R3: The fourth byte is the descriptor's parameter count, and a count of zero is legal.
- R4: Parameter bytes follow the count byte unchanged and in arrival order, and outLast is high only on the final byte of the packet.
- R5: descReady is high only while no packet is in progress, and after reset the block is idle with descReady high and outValid and parReady low.
- R6: With a parameter count of zero, exactly four bytes are emitted, outLast is high on the fourth, and parReady never goes high during that packet.
- R7: While outReady is low, outValid, outData and outLast hold their values, and no byte is dropped or emitted twice.
- R8: If parLast arrives on a byte that is not the declared last one, that byte is consumed but not emitted, lenErr pulses for one cycle, and the framer returns to idle. This happens even while outReady is low.
- R9: If the declared last parameter byte arrives with parLast low, that byte is consumed but not emitted, lenErr pulses, and the framer returns to idle.
- R10: One cycle after an event byte is input, the deframer presents it on dfData with dfValid. dfSop is high on each event's first byte. dfIsParam is low on the three header bytes (type, code, length at byte index 2) and high on the bytes after them.
- R11: dfEop is high on the length byte when the length is zero, and otherwise on the last parameter byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| descValid | input | 1 | Descriptor offered |
| descReady | output | 1 | Framer idle, descriptor accepted |
| descOpcode | input | 16 | Command opcode |
| descLen | input | 8 | Declared parameter byte count |
| parValid | input | 1 | Parameter byte offered |
| parReady | output | 1 | Parameter byte consumed |
| parData | input | 8 | Parameter byte |
| parLast | input | 1 | Marks the final parameter byte of the stream |
| outValid | output | 1 | Payload byte offered |
| outReady | input | 1 | Downstream takes the byte |
| outData | output | 8 | Payload byte |
| outLast | output | 1 | Final byte of the command |
| lenErr | output | 1 | One-cycle pulse on a length mismatch abort |
| evValid | input | 1 | Event byte present |
| evData | input | 8 | Event byte |
| dfValid | output | 1 | Deframed byte present |
| dfData | output | 8 | Deframed byte |
| dfSop | output | 1 | First byte of an event |
| dfEop | output | 1 | Last byte of an event |
| dfIsParam | output | 1 | Byte is an event parameter |

## Verification
A length mismatch and a downstream stall can land in the same cycle. The framer must then abort while the byte stays unemitted, rather than wait for outReady. The bench provokes this by holding outReady low from the first parameter byte of a packet whose stream ends at once. It expects a lenErr pulse with only the four header bytes delivered, and then an idle framer. Stalls inside the header and the parameter phase are also mixed with random parameter gaps. Every cycle that follows a stall is judged against the byte held in the cycle before.

// File: rtl/hci_frm_pkg.sv
package hci_frm_pkg;
  localparam logic [7:0] CMD_PKT_TYPE = 8'h01;
  localparam int EVT_HDR_N = 3;
  localparam int EVT_LEN_POS = 2;

  typedef enum logic [1:0] {
    FS_IDLE,
    FS_HDR,
    FS_PAR
  } frmState_t;

  typedef struct packed {
    logic load;
    logic hdrStep;
    logic parStep;
    logic selPar;
  } frmStrobe_t;
endpackage

// File: rtl/frm_datapath.sv
module frm_datapath
  import hci_frm_pkg::*;
#(
  parameter int OPC_W = 16,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  frmStrobe_t       stb,
  input  logic [OPC_W-1:0] descOpcode,
  input  logic [LEN_W-1:0] descLen,
  input  logic [7:0]       parData,
  output logic [7:0]       outData,
  output logic             hdrLast,
  output logic             lenZero,
  output logic             remOne
);
  localparam int HDR_N = 1 + OPC_W / 8 + LEN_W / 8;
  localparam int IDX_W = (HDR_N > 2) ? $clog2(HDR_N) : 1;

  logic [OPC_W-1:0] opcQ;
  logic [LEN_W-1:0] lenQ;
  logic [LEN_W-1:0] remQ;
  logic [IDX_W-1:0] idxQ;
  logic [HDR_N*8-1:0] hdrVec;
  logic [7:0] hdrByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcQ <= '0;
      lenQ <= '0;
      remQ <= '0;
      idxQ <= '0;
    end else begin
      if (stb.load) begin
        opcQ <= descOpcode;
        lenQ <= descLen;
        remQ <= descLen;
        idxQ <= '0;
      end else begin
        if (stb.hdrStep) idxQ <= idxQ + 1'b1;
        if (stb.parStep) remQ <= remQ - 1'b1;
      end
    end
  end

  // little-endian header image: type byte lowest, count highest
  assign hdrVec = {lenQ, opcQ, CMD_PKT_TYPE};

  always_comb begin
    hdrByte = 8'h00;
    for (int i = 0; i < HDR_N; i++) begin
      if (idxQ == IDX_W'(i)) hdrByte = hdrVec[i*8 +: 8];
    end
  end

  assign outData = stb.selPar ? parData : hdrByte;
  assign hdrLast = (idxQ == IDX_W'(HDR_N - 1));
  assign lenZero = (lenQ == '0);
  assign remOne  = (remQ == LEN_W'(1));
endmodule

// File: rtl/frm_control.sv
module frm_control
  import hci_frm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       descValid,
  input  logic       outReady,
  input  logic       parValid,
  input  logic       parLast,
  input  logic       hdrLast,
  input  logic       lenZero,
  input  logic       remOne,
  output logic       descReady,
  output logic       outValid,
  output logic       outLast,
  output logic       parReady,
  output logic       lenErr,
  output frmStrobe_t stb
);
  frmState_t stQ, stNxt;
  logic mismatch;

  always_ff @(posedge clk) begin
    if (!rstN) stQ <= FS_IDLE;
    else       stQ <= stNxt;
  end

  assign mismatch = parValid && (parLast != remOne);

  always_comb begin
    stb       = '0;
    stNxt     = stQ;
    descReady = 1'b0;
    outValid  = 1'b0;
    outLast   = 1'b0;
    parReady  = 1'b0;
    lenErr    = 1'b0;
    unique case (stQ)
      FS_IDLE: begin
        descReady = 1'b1;
        if (descValid) begin
          stb.load = 1'b1;
          stNxt    = FS_HDR;
        end
      end
      FS_HDR: begin
        outValid = 1'b1;
        outLast  = hdrLast && lenZero;
        if (outReady) begin
          stb.hdrStep = 1'b1;
          if (hdrLast) stNxt = lenZero ? FS_IDLE : FS_PAR;
        end
      end
      FS_PAR: begin
        stb.selPar = 1'b1;
        if (mismatch) begin
          // swallow the offending byte and abort, stall or not
          parReady = 1'b1;
          lenErr   = 1'b1;
          stNxt    = FS_IDLE;
        end else begin
          outValid = parValid;
          outLast  = parValid && remOne;
          parReady = outReady;
          if (parValid && outReady) begin
            stb.parStep = 1'b1;
            if (remOne) stNxt = FS_IDLE;
          end
        end
      end
      default: stNxt = FS_IDLE;
    endcase
  end
endmodule

// File: rtl/evt_deframer.sv
module evt_deframer
  import hci_frm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evValid,
  input  logic [7:0] evData,
  output logic       dfValid,
  output logic [7:0] dfData,
  output logic       dfSop,
  output logic       dfEop,
  output logic       dfIsParam
);
  localparam int POS_W = $clog2(EVT_HDR_N + 1);

  logic             inPkt;
  logic [POS_W-1:0] posQ;
  logic [7:0]       remQ;
  logic [POS_W-1:0] curPos;
  logic             isHdr, isLenByte, isEop;

  assign curPos    = inPkt ? posQ : '0;
  assign isHdr     = (curPos < POS_W'(EVT_HDR_N));
  assign isLenByte = (curPos == POS_W'(EVT_LEN_POS));
  assign isEop     = isLenByte ? (evData == 8'h00) : (!isHdr && remQ == 8'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPkt     <= 1'b0;
      posQ      <= '0;
      remQ      <= '0;
      dfValid   <= 1'b0;
      dfData    <= '0;
      dfSop     <= 1'b0;
      dfEop     <= 1'b0;
      dfIsParam <= 1'b0;
    end else begin
      dfValid   <= evValid;
      dfSop     <= evValid && !inPkt;
      dfEop     <= evValid && isEop;
      dfIsParam <= evValid && !isHdr;
      if (evValid) begin
        dfData <= evData;
        if (isEop) begin
          inPkt <= 1'b0;
          posQ  <= '0;
        end else begin
          inPkt <= 1'b1;
          if (isHdr) posQ <= curPos + 1'b1;
          if (isLenByte) remQ <= evData;
          else if (!isHdr) remQ <= remQ - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hci_pkt_framer.sv
module hci_pkt_framer
  import hci_frm_pkg::*;
#(
  parameter int OPC_W = 16,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             descValid,
  output logic             descReady,
  input  logic [OPC_W-1:0] descOpcode,
  input  logic [LEN_W-1:0] descLen,
  input  logic             parValid,
  output logic             parReady,
  input  logic [7:0]       parData,
  input  logic             parLast,
  output logic             outValid,
  input  logic             outReady,
  output logic [7:0]       outData,
  output logic             outLast,
  output logic             lenErr,
  input  logic             evValid,
  input  logic [7:0]       evData,
  output logic             dfValid,
  output logic [7:0]       dfData,
  output logic             dfSop,
  output logic             dfEop,
  output logic             dfIsParam
);
  frmStrobe_t stb;
  logic hdrLast, lenZero, remOne;

  frm_control u_ctl (
    .clk(clk), .rstN(rstN),
    .descValid(descValid), .outReady(outReady),
    .parValid(parValid), .parLast(parLast),
    .hdrLast(hdrLast), .lenZero(lenZero), .remOne(remOne),
    .descReady(descReady), .outValid(outValid), .outLast(outLast),
    .parReady(parReady), .lenErr(lenErr), .stb(stb)
  );

  frm_datapath #(.OPC_W(OPC_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .descOpcode(descOpcode), .descLen(descLen), .parData(parData),
    .outData(outData), .hdrLast(hdrLast), .lenZero(lenZero), .remOne(remOne)
  );

  evt_deframer u_dfr (
    .clk(clk), .rstN(rstN),
    .evValid(evValid), .evData(evData),
    .dfValid(dfValid), .dfData(dfData), .dfSop(dfSop),
    .dfEop(dfEop), .dfIsParam(dfIsParam)
  );
endmodule

// File: rtl/hci_pkt_framer_chk.sv
module hci_pkt_framer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       descValid,
  input logic       descReady,
  input logic       parValid,
  input logic       parReady,
  input logic       outValid,
  input logic       outReady,
  input logic [7:0] outData,
  input logic       outLast,
  input logic       lenErr,
  input logic       evValid,
  input logic       dfValid,
  input logic       dfSop,
  input logic       dfEop
);
  a_r1_type_first: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && descReady) |=> (outValid && outData == 8'h01));

  a_r4_last_with_valid: assert property (@(posedge clk) disable iff (!rstN)
    outLast |-> outValid);

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    descReady |-> (!outValid && !parReady));

  a_r7_no_drop: assert property (@(posedge clk) disable iff (!rstN)
    (parValid && parReady && !lenErr) |-> (outValid && outReady));

  a_r8_abort_silent: assert property (@(posedge clk) disable iff (!rstN)
    lenErr |-> (!outValid && parReady && parValid));

  a_r8_back_idle: assert property (@(posedge clk) disable iff (!rstN)
    lenErr |=> descReady);

  a_r10_sop_valid: assert property (@(posedge clk) disable iff (!rstN)
    dfSop |-> dfValid);

  a_r10_follows_input: assert property (@(posedge clk) disable iff (!rstN)
    dfValid |-> $past(evValid));

  a_r11_eop_valid: assert property (@(posedge clk) disable iff (!rstN)
    dfEop |-> dfValid);
endmodule

bind hci_pkt_framer hci_pkt_framer_chk u_chk (.*);

// File: tb/hci_pkt_framer_tb.sv
module hci_pkt_framer_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN;
  logic descValid, descReady;
  logic [15:0] descOpcode;
  logic [7:0] descLen;
  logic parValid, parReady, parLast;
  logic [7:0] parData;
  logic outValid, outReady, outLast, lenErr;
  logic [7:0] outData;
  logic evValid;
  logic [7:0] evData;
  logic dfValid, dfSop, dfEop, dfIsParam;
  logic [7:0] dfData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int readyPct = 75;
  bit holdAfterHdr = 0;

  logic [7:0] parBuf [256];
  logic [7:0] expB [260];

  always #(CLK_PERIOD/2) clk = ~clk;

  hci_pkt_framer u_dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog R7 actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  // mode 0 exact, 1 parLast early at errAt, 2 parLast missing
  task automatic run_frame(input logic [15:0] op, input int len, input int mode, input int errAt);
    int nSend, expPar, expTotal, pIdx, nOut, cyc;
    bit accepted, done, gotErr, sawParReady, prevStall, prevLast, badLast;
    logic [7:0] prevData;
    string tag;
    for (int i = 0; i < len; i++) parBuf[i] = 8'($urandom);
    expB[0] = 8'h01; expB[1] = op[7:0]; expB[2] = op[15:8]; expB[3] = 8'(len);
    for (int i = 0; i < len; i++) expB[4+i] = parBuf[i];
    nSend  = (mode == 1) ? errAt + 1 : len;
    expPar = (mode == 0) ? len : ((mode == 1) ? errAt : len - 1);
    expTotal = 4 + expPar;
    pIdx = 0; nOut = 0; cyc = 0;
    accepted = 0; done = 0; gotErr = 0; sawParReady = 0; prevStall = 0;
    prevLast = 0; prevData = 0; badLast = 0;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      descValid = !accepted;
      descOpcode = op;
      descLen = 8'(len);
      if (holdAfterHdr && nOut >= 4) outReady = 1'b0;
      else outReady = (($urandom % 100) < readyPct);
      if (!parValid) parValid = (pIdx < nSend) && (($urandom % 4) != 0);
      else parValid = (pIdx < nSend);
      parData = parBuf[pIdx[7:0]];
      parLast = (mode == 1 && pIdx == errAt) || (mode == 0 && pIdx == len - 1);
      #1;
      if (prevStall) begin
        chk(outValid && outData == prevData && outLast == prevLast,
            "R7 stalled output changed", {23'd0, outValid, outData}, {23'd1, prevData});
      end
      if (descValid && descReady) accepted = 1;
      if (parReady) sawParReady = 1;
      if (outValid && outReady) begin
        tag = (nOut == 0) ? "R1 type byte" : (nOut < 3) ? "R2 opcode byte" :
              (nOut == 3) ? "R3 count byte" : "R4 parameter byte";
        chk(nOut < expTotal && outData == expB[nOut], tag, outData, expB[nOut]);
        if (outLast) begin
          done = 1;
          if (mode != 0 || nOut != expTotal - 1) badLast = 1;
        end
        nOut++;
      end
      if (lenErr) begin
        gotErr = 1;
        done = 1;
      end
      if (parValid && parReady) pIdx++;
      prevStall = outValid && !outReady && !lenErr;
      prevData = outData;
      prevLast = outLast;
    end
    @(negedge clk);
    descValid = 0; parValid = 0; parLast = 0; outReady = 1;
    #1;
    chk(!badLast, "R4 outLast placement", nOut, expTotal);
    chk(nOut == expTotal, (mode == 0) ? "R4 byte count" : "R8 R9 bytes before abort", nOut, expTotal);
    if (mode == 1) chk(gotErr, "R8 early end flagged", gotErr, 1);
    else if (mode == 2) chk(gotErr, "R9 late end flagged", gotErr, 1);
    else chk(!gotErr, "R4 no spurious error", gotErr, 0);
    if (len == 0 && mode == 0) chk(!sawParReady, "R6 parReady stayed low", sawParReady, 0);
    chk(descReady && !outValid && !lenErr, "R5 idle after packet", {descReady, outValid, lenErr}, 3'b100);
  endtask

  task automatic run_events(input int nEv);
    logic [7:0] eb [1024];
    bit es [1024], ee [1024], ep [1024];
    int n, k, ln;
    bit expV, expS, expE, expP;
    logic [7:0] expD;
    n = 0;
    for (int e = 0; e < nEv; e++) begin
      ln = (e % 4 == 0) ? 0 : (e % 4 == 1) ? 1 : int'($urandom % 12);
      eb[n] = 8'h04; es[n] = 1; ee[n] = 0; ep[n] = 0; n++;
      eb[n] = 8'($urandom); es[n] = 0; ee[n] = 0; ep[n] = 0; n++;
      eb[n] = 8'(ln); es[n] = 0; ee[n] = (ln == 0); ep[n] = 0; n++;
      for (int p = 0; p < ln; p++) begin
        eb[n] = 8'($urandom); es[n] = 0; ee[n] = (p == ln - 1); ep[n] = 1; n++;
      end
    end
    k = 0; expV = 0; expS = 0; expE = 0; expP = 0; expD = 0;
    while (k < n || expV) begin
      @(negedge clk);
      chk(dfValid == expV, "R10 dfValid timing", dfValid, expV);
      if (expV) begin
        chk(dfData == expD, "R10 dfData", dfData, expD);
        chk(dfSop == expS && dfIsParam == expP, "R10 sop and header flag",
            {dfSop, dfIsParam}, {expS, expP});
        chk(dfEop == expE, "R11 eop", dfEop, expE);
      end
      evValid = (k < n) && (($urandom % 3) != 0);
      evData = (k < n) ? eb[k] : 8'h00;
      expV = evValid;
      if (evValid) begin
        expD = eb[k]; expS = es[k]; expE = ee[k]; expP = ep[k];
        k++;
      end
    end
    @(negedge clk);
    evValid = 0;
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h1f3d);
    rstN = 0; descValid = 0; descOpcode = 0; descLen = 0;
    parValid = 0; parData = 0; parLast = 0; outReady = 1;
    evValid = 0; evData = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk); #1;
    chk(descReady && !outValid && !parReady, "R5 reset idle",
        {descReady, outValid, parReady}, 3'b100);
    chk(!lenErr && !dfValid, "R8 R10 reset quiet", {lenErr, dfValid}, 2'b00);

    readyPct = 100;
    run_frame(16'hA55A, 0, 0, 0);   // R6 zero-length
    run_frame(16'h1234, 1, 0, 0);
    run_frame(16'hFC03, 5, 0, 0);
    readyPct = 30;                  // heavy stalls, R7
    run_frame(16'h0102, 0, 0, 0);
    run_frame(16'hBEEF, 9, 0, 0);
    readyPct = 75;
    for (int i = 0; i < 12; i++) run_frame(16'($urandom), int'($urandom % 21), 0, 0);
    run_frame(16'h7E81, 255, 0, 0);
    run_frame(16'h2222, 6, 1, 2);   // R8 early
    run_frame(16'h3333, 4, 2, 0);   // R9 late
    run_frame(16'h4444, 1, 2, 0);   // R9 single byte missing last
    holdAfterHdr = 1;               // R8 abort while stalled
    run_frame(16'h5555, 3, 1, 0);
    holdAfterHdr = 0;
    run_frame(16'h6666, 2, 0, 0);   // recovers after abort

    run_events(16);
    finish_run();
  end
endmodule